// File: doc/BRIEF.md
# Serial DAC Write Controller

The block loads one 12-bit sample into one of four channels of a serial digital-to-analog converter. The caller presents a 2-bit channel number and a 12-bit value together with a one-cycle start strobe. The block then builds a 16-bit command word. The word holds the channel in its top two bits, two fixed mode bits that select internal clocking and the bipolar ±5 V range, and the value in its low twelve bits. The block shifts the word out on a serial clock and data pair, most significant bit first. The upper byte (channel, mode and value bits 11..8) goes out first, then the lower byte (value bits 7..0).

The converter shares its serial clock and data lines with another converter, so the block drives its own active-low chip select and keeps the data line low whenever it is not framing a word. The caller is responsible for keeping the other converter off the shared lines while a write is in progress. The block announces the end of each write with a single-cycle done pulse, raised in the same cycle that chip select returns high. The serial clock half-period, counted in system clocks, is a parameter.

Top module: `dac_serial_writer`

## Requirements
- R1: During and directly after reset, cs_n is 1, sclk is 0, din is 0, done is 0 and busy is 0, even if reset arrives in the middle of a write.
- R2: Bits 15..14 of the transmitted word (bits 7..6 of the first byte) equal the channel input captured with the start strobe.
- R3: Bits 13..12 of the transmitted word (bits 5..4 of the first byte) are both 1.
- R4: Bits 11..0 of the transmitted word equal the value input captured with the start strobe. The word is sent upper byte first and most significant bit first, and din is sampled at each sclk rising edge.
- R5: Each write produces exactly 16 sclk rising edges, and every sclk high phase lasts HALF_CYC system clocks.
- R6: cs_n falls before the first sclk rising edge, stays low for all 16 pulses and rises only after the sixteenth pulse has ended. sclk is 0 whenever cs_n is 1.
- R7: din never changes while sclk is high.
- R8: A start strobe is acted on only while busy is 0. A strobe during a write changes neither the word being sent nor the frame timing.
- R9: done is high for exactly one cycle per write, in a cycle where cs_n is 1. busy is 0 in the following cycle.
- R10: din is 0 whenever cs_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to write a sample; honoured only when idle |
| chan | input | 2 | Target converter channel, captured with start |
| value | input | 12 | Sample code, captured with start |
| sclk | output | 1 | Serial clock to the converter, idles low |
| din | output | 1 | Serial data to the converter, valid on sclk rising edges |
| cs_n | output | 1 | Active-low chip select of this converter |
| busy | output | 1 | High from the cycle after start is accepted until done |
| done | output | 1 | One-cycle pulse at the end of a write |

## Verification
The main function is tried with channel and value pairs covering all four channels. The values include all zeros and all ones, which show whether the fixed mode bits are placed apart from the value field. Alternating patterns such as 0xA5C and 0x5A3 catch swapped bytes or a reversed bit order. Single-bit values such as 0x800 and 0x001 pin the exact position of the value's top and bottom bits inside the two bytes. Directed cases strobe start in the middle of a write with different inputs, to show that they are ignored, and apply reset in the middle of a frame, to show that the lines drop back to idle at once.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOW  = 3'd1,
    ST_HIGH = 3'd2,
    ST_TAIL = 3'd3,
    ST_DONE = 3'd4
  } wr_state_e;

  // True for the states in which the serial clock phases are being timed.
  function automatic logic is_timed(input wr_state_e s);
    return (s == ST_LOW) || (s == ST_HIGH) || (s == ST_TAIL);
  endfunction

  // True for the states in which a data bit is presented on the line.
  function automatic logic shows_bit(input wr_state_e s);
    return (s == ST_LOW) || (s == ST_HIGH);
  endfunction

endpackage

// File: rtl/dacw_phase_timer.sv
module dacw_phase_timer #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_end
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign phase_end = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || phase_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  initial begin
    assert (HALF_CYC >= 1) else $error("HALF_CYC must be at least one");
  end

endmodule

// File: rtl/dacw_shifter.sv
module dacw_shifter #(
  parameter int WORD_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic                      shift,
  input  logic [WORD_W-1:0]         load_word,
  output logic                      msb,
  output logic [$clog2(WORD_W)-1:0] bit_idx,
  output logic                      last_bit
);
  localparam int IW = $clog2(WORD_W);
  localparam logic [IW-1:0] LAST_IDX = IW'(WORD_W - 1);

  logic [WORD_W-1:0] sreg_q;
  logic [IW-1:0]     idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      sreg_q <= load_word;
      idx_q  <= '0;
    end else if (shift) begin
      sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
      idx_q  <= idx_q + IW'(1);
    end
  end

  assign msb      = sreg_q[WORD_W-1];
  assign bit_idx  = idx_q;
  assign last_bit = (idx_q == LAST_IDX);

  // R5: no shift is requested beyond the final bit of the word
  assert_no_shift_past_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> !last_bit);

endmodule

// File: rtl/dacw_ctrl.sv
module dacw_ctrl
  import dacw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic phase_end,
  input  logic last_bit,
  output logic load,
  output logic shift,
  output logic run,
  output logic show_bit,
  output logic sclk,
  output logic cs_n,
  output logic busy,
  output logic done
);
  wr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    shift   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_LOW;
          load    = 1'b1;
        end
      end
      ST_LOW: begin
        if (phase_end) state_d = ST_HIGH;
      end
      ST_HIGH: begin
        if (phase_end) begin
          if (last_bit) begin
            state_d = ST_TAIL;
          end else begin
            state_d = ST_LOW;
            shift   = 1'b1;
          end
        end
      end
      ST_TAIL: begin
        if (phase_end) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sclk     <= 1'b0;
      cs_n     <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
      show_bit <= 1'b0;
    end else begin
      state_q  <= state_d;
      sclk     <= (state_d == ST_HIGH);
      cs_n     <= !is_timed(state_d);
      busy     <= (state_d != ST_IDLE);
      done     <= (state_d == ST_DONE);
      show_bit <= shows_bit(state_d);
    end
  end

  assign run = is_timed(state_q);

  // R6: the serial clock is only ever high inside a chip-select frame
  assert_sclk_inside_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R9: done lasts a single cycle
  assert_done_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: the controller is idle the cycle after done
  assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/dac_serial_writer.sv
module dac_serial_writer #(
  parameter int HALF_CYC  = 2,
  parameter int CH_W      = 2,
  parameter int VAL_W     = 12,
  parameter int MODE_W    = 2,
  parameter logic [MODE_W-1:0] MODE_BITS = 2'b11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CH_W-1:0]  chan,
  input  logic [VAL_W-1:0] value,
  output logic             sclk,
  output logic             din,
  output logic             cs_n,
  output logic             busy,
  output logic             done
);
  localparam int WORD_W = CH_W + MODE_W + VAL_W;
  localparam int IW     = $clog2(WORD_W);

  // Command word: channel on top, fixed mode bits, then the sample code.
  function automatic logic [WORD_W-1:0] pack_cmd(input logic [CH_W-1:0] c,
                                                 input logic [VAL_W-1:0] v);
    return {c, MODE_BITS, v};
  endfunction

  logic          load_ev;
  logic          shift_ev;
  logic          run;
  logic          phase_end;
  logic          last_bit;
  logic          show_bit;
  logic          msb;
  logic [IW-1:0] bit_idx;

  dacw_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .phase_end (phase_end)
  );

  dacw_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_ev),
    .shift     (shift_ev),
    .load_word (pack_cmd(chan, value)),
    .msb       (msb),
    .bit_idx   (bit_idx),
    .last_bit  (last_bit)
  );

  dacw_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .phase_end (phase_end),
    .last_bit  (last_bit),
    .load      (load_ev),
    .shift     (shift_ev),
    .run       (run),
    .show_bit  (show_bit),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .busy      (busy),
    .done      (done)
  );

  assign din = show_bit & msb;

  // R7: data moves only while the serial clock is low
  assert_din_steady_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(din) |-> !sclk);

  // R10: data line rests low outside a frame
  assert_din_low_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !din);

  // R9: done coincides with a released chip select
  assert_done_cs_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);

  // R8: a strobe during a write neither reloads nor rewinds the bit index
  assert_start_ignored_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (bit_idx == $past(bit_idx) || bit_idx == $past(bit_idx) + IW'(1)));

  // R6: a rising serial clock always lies inside the frame
  assert_rise_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !cs_n);

endmodule

// File: tb/dac_serial_writer_tb.sv
module dac_serial_writer_tb;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  chan = '0;
  logic [11:0] value = '0;
  logic        sclk, din, cs_n, busy, done;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  dac_serial_writer #(.HALF_CYC(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .value(value),
    .sclk(sclk), .din(din), .cs_n(cs_n), .busy(busy), .done(done)
  );

  // stimulus table: {channel, value}
  localparam logic [13:0] VEC [6] = '{
    {2'd0, 12'h000}, {2'd3, 12'hFFF}, {2'd1, 12'hA5C},
    {2'd2, 12'h5A3}, {2'd3, 12'h800}, {2'd0, 12'h001}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // results of the last frame
  logic [15:0] got;
  int pulses, dones, hi_bad, din_hi_bad, cs_order_bad, done_cs_bad, idle_din_bad;
  bit timed_out;

  task automatic run_frame(input logic [1:0] ch, input logic [11:0] val, input bit poke);
    bit prev_sclk, prev_din;
    int hi_w;
    @(negedge clk);
    start = 1'b1; chan = ch; value = val;
    @(negedge clk);
    start = 1'b0; chan = ~ch; value = ~val;
    got = '0; pulses = 0; dones = 0; hi_bad = 0; din_hi_bad = 0;
    cs_order_bad = 0; done_cs_bad = 0; idle_din_bad = 0; timed_out = 1'b1;
    prev_sclk = 1'b0; prev_din = din; hi_w = 0;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      if (poke) start = (c == 40);
      if (sclk && !prev_sclk) begin
        pulses++;
        got = {got[14:0], din};
        if (cs_n) cs_order_bad++;
      end
      if (sclk && prev_sclk && din != prev_din) din_hi_bad++;
      if (sclk) hi_w++;
      else if (prev_sclk) begin
        if (hi_w != HALF) hi_bad++;
        hi_w = 0;
      end
      if (cs_n && din) idle_din_bad++;
      if (cs_n && pulses > 0 && pulses < 16) cs_order_bad++;
      if (done) begin
        dones++;
        if (!cs_n) done_cs_bad++;
      end else if (dones > 0) begin
        timed_out = 1'b0;
        break;
      end
      prev_sclk = sclk; prev_din = din;
    end
    start = 1'b0;
  endtask

  task automatic judge(input logic [1:0] ch, input logic [11:0] val);
    logic [15:0] exp_w;
    exp_w = (16'(ch) << 14) | 16'h3000 | 16'(val);
    check(!timed_out, "R9 frame end", int'(timed_out), 0);
    check(got[15:14] == ch, "R2 channel bits", int'(got[15:14]), int'(ch));
    check(got[13:12] == 2'b11, "R3 mode bits", int'(got[13:12]), 3);
    check(got == exp_w, "R4 word", int'(got), int'(exp_w));
    check(pulses == 16, "R5 pulse count", pulses, 16);
    check(hi_bad == 0, "R5 high width", hi_bad, 0);
    check(cs_order_bad == 0, "R6 cs framing", cs_order_bad, 0);
    check(din_hi_bad == 0, "R7 din steady high", din_hi_bad, 0);
    check(dones == 1 && done_cs_bad == 0, "R9 done pulse", dones, 1);
    check(idle_din_bad == 0, "R10 din idle low", idle_din_bad, 0);
    check(!busy && cs_n, "R9 idle after done", int'(busy), 0);
  endtask

  initial begin
    fork
      begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    // R1: reset state
    check(cs_n && !sclk && !din && !done && !busy, "R1 reset outputs",
          {cs_n, sclk, din, done, busy}, 5'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(cs_n && !busy && !din, "R1 idle after reset", {cs_n, busy, din}, 3'b100);

    for (int i = 0; i < 6; i++) begin
      run_frame(VEC[i][13:12], VEC[i][11:0], 1'b0);
      judge(VEC[i][13:12], VEC[i][11:0]);
    end

    // R8: start strobe mid-frame with different inputs is ignored
    run_frame(2'd1, 12'h3C5, 1'b1);
    judge(2'd1, 12'h3C5);
    check(got == 16'h73C5, "R8 strobe while busy ignored", int'(got), 16'h73C5);

    // R1: reset in the middle of a frame
    @(negedge clk);
    start = 1'b1; chan = 2'd2; value = 12'hFFF;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(cs_n && !sclk && !din && !done && !busy, "R1 reset mid-frame",
          {cs_n, sclk, din, done, busy}, 5'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_frame(2'd2, 12'h0F0, 1'b0);
    judge(2'd2, 12'h0F0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule